// File: doc/BRIEF.md
# Serial Receive Buffer with Per-Character Status

This block is the receive-side buffer of one serial channel. The deserialiser in front of it hands over one character at a time, together with three error indications: break, framing and parity. The buffer holds up to 1023 characters. Each stored entry keeps the character's error bits beside its data byte. A marker is also stored that shows characters were lost just before this one.

Software, or a host-side engine, reads the oldest character through a 16-bit word. With status mode on, the upper byte of that word carries the character's own error bits. With status mode off, the upper byte reads as zero. A separate status word gives summary flags that accumulate until the word is read. A fill-level trigger can be pointed at one character, half full or seven-eighths full. A clear command empties the buffer in one cycle.

Top module: `rxf_status_fifo`

## Requirements
- R1: After reset, the count is 0, data_avail is 0, trig is 0, the overflow, break, framing and parity summary flags are 0, and rd_word is 0x0000.
- R2: Characters leave in arrival order. The buffer holds up to 1023 characters and rx_count tracks the number held. A store and a pop in the same cycle leave the count unchanged, even when the buffer is full. A pop on an empty buffer is ignored.
- R3: A character that arrives while the buffer is full, with no pop in that cycle, is dropped. The drop sets the overflow flag (status bit 13). The next character that is stored carries the overrun bit (read-word bit 9), and later characters do not.
- R4: rd_word bits 7:0 hold the oldest character. With stat_mode high, bits 11, 10, 9 and 8 hold that character's break, framing, overrun and parity bits, and bits 15:12 are zero. With stat_mode low, bits 15:8 are zero. When the buffer is empty, rd_word is 0x0000.
- R5: stat_word layout: bit 15 follows stat_mode, bit 13 is overflow, bit 10 is break, bit 9 is framing, bit 8 is parity and bit 0 is data available. All other bits are zero. The break, framing and parity flags are set by the flags of any character that is stored.
- R6: A cycle with stat_rd high clears bits 13, 10, 9 and 8 from the next cycle on. An event in that same cycle leaves its own flag set.
- R7: cnt_clr empties the buffer in one cycle. It takes priority over a store or a pop in the same cycle (the arriving character is discarded without setting overflow), and it leaves the summary flags unchanged.
- R8: trig_sel values 0, 1, 2 and 3 select never, count ≥ 1, count ≥ 512 and count ≥ 896. trig is high while the selected condition holds.
- R9: data_avail is high exactly when rx_count is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| char_vld | input | 1 | A received character is presented this cycle |
| char_data | input | 8 | Received character |
| char_brk | input | 1 | Character was a break |
| char_frm | input | 1 | Character had a framing error |
| char_par | input | 1 | Character had a parity error |
| stat_mode | input | 1 | Status mode: read word carries the error byte |
| trig_sel | input | 2 | Trigger threshold select |
| cnt_clr | input | 1 | Empty the buffer |
| rd_en | input | 1 | Pop the oldest character |
| stat_rd | input | 1 | Status word read; clears summary flags |
| rd_word | output | 16 | Oldest character, with its status in status mode |
| rx_count | output | 10 | Number of characters held |
| data_avail | output | 1 | Buffer not empty |
| trig | output | 1 | Fill level at or above the selected threshold |
| stat_word | output | 16 | Mode bit, summary flags and data available |

## Verification
Two groups of events can land in the same cycle. The first is a status-word read together with an incoming character that carries an error. The bench drives stat_rd and a parity-flagged character in the same cycle. It expects the parity bit to stay set and the overflow bit, which had no new event, to be cleared. The second is a store together with a pop while the buffer is full. The bench fills all 1023 entries and then drives char_vld and rd_en together. It judges the result by a count that stays at 1023 and an overflow bit that stays clear. A lone store that follows must then set the overflow bit. A clear issued in the same cycle as a store is also driven, and it must leave the count at zero.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    // One stored character: error bits above the data byte, ordered so that
    // the entry is exactly bits 11:0 of the status-mode read word.
    typedef struct packed {
        logic       brk;
        logic       frm;
        logic       ovr;
        logic       par;
        logic [7:0] data;
    } rxf_entry_t;

    localparam int ENTRY_W = $bits(rxf_entry_t);

    // Trigger threshold selections
    typedef enum logic [1:0] {
        TRIG_OFF   = 2'd0,
        TRIG_ONE   = 2'd1,
        TRIG_HALF  = 2'd2,
        TRIG_SEVEN = 2'd3
    } trig_sel_e;

endpackage

// File: rtl/rxf_level.sv
module rxf_level #(
    parameter int DEPTH = 1023,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  logic             pop_req,
    input  logic             clr,
    input  logic [1:0]       trig_sel,
    output logic             push_ok,
    output logic             pop_ok,
    output logic             drop,
    output logic [CNT_W-1:0] count,
    output logic             trig
);
    import rxf_pkg::*;

    localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] HALF_CNT  = CNT_W'((DEPTH + 1) / 2);
    localparam logic [CNT_W-1:0] SEVEN_CNT = CNT_W'(((DEPTH + 1) * 7) / 8);
    localparam logic [CNT_W-1:0] ONE_CNT   = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } lvl_state_t;

    lvl_state_t st_q, st_d;
    logic [CNT_W-1:0] thr;

    always_comb begin
        st_d    = st_q;
        pop_ok  = pop_req && (st_q.count != '0) && !clr;
        push_ok = push_req && !clr && ((st_q.count != FULL_CNT) || pop_ok);
        drop    = push_req && !clr && !push_ok;
        if (clr) begin
            st_d.count = '0;
        end else begin
            unique case ({push_ok, pop_ok})
                2'b10:   st_d.count = st_q.count + ONE_CNT;
                2'b01:   st_d.count = st_q.count - ONE_CNT;
                default: st_d.count = st_q.count;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (trig_sel_e'(trig_sel))
            TRIG_ONE:   thr = ONE_CNT;
            TRIG_HALF:  thr = HALF_CNT;
            TRIG_SEVEN: thr = SEVEN_CNT;
            default:    thr = '0;
        endcase
        trig  = (trig_sel_e'(trig_sel) != TRIG_OFF) && (st_q.count >= thr);
        count = st_q.count;
    end

endmodule

// File: rtl/rxf_store.sv
module rxf_store #(
    parameter int DEPTH = 1023,
    parameter int PTR_W = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic                rd,
    input  logic                clr,
    input  rxf_pkg::rxf_entry_t wr_entry,
    output rxf_pkg::rxf_entry_t head
);
    import rxf_pkg::*;

    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
    } ptr_state_t;

    ptr_state_t st_q, st_d;
    rxf_entry_t mem [DEPTH];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.wr_ptr = '0;
            st_d.rd_ptr = '0;
        end else begin
            if (wr) st_d.wr_ptr = bump(st_q.wr_ptr);
            if (rd) st_d.rd_ptr = bump(st_q.rd_ptr);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (wr) mem[st_q.wr_ptr] <= wr_entry;
    end

    assign head = mem[st_q.rd_ptr];

endmodule

// File: rtl/rxf_flags.sv
module rxf_flags (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        store,
    input  logic        drop,
    input  logic        in_brk,
    input  logic        in_frm,
    input  logic        in_par,
    input  logic        stat_rd,
    input  logic        stat_mode,
    input  logic        avail,
    output logic        ovr_mark,
    output logic [15:0] stat_word
);

    typedef struct packed {
        logic ovfl;
        logic brk;
        logic frm;
        logic par;
        logic pend_ovr;
    } flag_state_t;

    flag_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (stat_rd) begin
            st_d.ovfl = 1'b0;
            st_d.brk  = 1'b0;
            st_d.frm  = 1'b0;
            st_d.par  = 1'b0;
        end
        // New events win over a read in the same cycle
        if (drop) begin
            st_d.ovfl     = 1'b1;
            st_d.pend_ovr = 1'b1;
        end
        if (store) begin
            st_d.pend_ovr = 1'b0;
            if (in_brk) st_d.brk = 1'b1;
            if (in_frm) st_d.frm = 1'b1;
            if (in_par) st_d.par = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ovr_mark  = st_q.pend_ovr;
    assign stat_word = {stat_mode, 1'b0, st_q.ovfl, 2'b00,
                        st_q.brk, st_q.frm, st_q.par, 7'b0, avail};

endmodule

// File: rtl/rxf_status_fifo.sv
module rxf_status_fifo #(
    parameter int DEPTH = 1023,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             char_vld,
    input  logic [7:0]       char_data,
    input  logic             char_brk,
    input  logic             char_frm,
    input  logic             char_par,
    input  logic             stat_mode,
    input  logic [1:0]       trig_sel,
    input  logic             cnt_clr,
    input  logic             rd_en,
    input  logic             stat_rd,
    output logic [15:0]      rd_word,
    output logic [CNT_W-1:0] rx_count,
    output logic             data_avail,
    output logic             trig,
    output logic [15:0]      stat_word
);
    import rxf_pkg::*;

    localparam int PTR_W = $clog2(DEPTH);

    logic       push_ok, pop_ok, drop, ovr_mark;
    rxf_entry_t wr_entry, head;

    rxf_level #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_level (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (char_vld),
        .pop_req  (rd_en),
        .clr      (cnt_clr),
        .trig_sel (trig_sel),
        .push_ok  (push_ok),
        .pop_ok   (pop_ok),
        .drop     (drop),
        .count    (rx_count),
        .trig     (trig)
    );

    always_comb begin
        wr_entry      = '0;
        wr_entry.brk  = char_brk;
        wr_entry.frm  = char_frm;
        wr_entry.ovr  = ovr_mark;
        wr_entry.par  = char_par;
        wr_entry.data = char_data;
    end

    rxf_store #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (push_ok),
        .rd       (pop_ok),
        .clr      (cnt_clr),
        .wr_entry (wr_entry),
        .head     (head)
    );

    assign data_avail = (rx_count != '0);

    rxf_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .store     (push_ok),
        .drop      (drop),
        .in_brk    (char_brk),
        .in_frm    (char_frm),
        .in_par    (char_par),
        .stat_rd   (stat_rd),
        .stat_mode (stat_mode),
        .avail     (data_avail),
        .ovr_mark  (ovr_mark),
        .stat_word (stat_word)
    );

    always_comb begin
        if (!data_avail)    rd_word = '0;
        else if (stat_mode) rd_word = {(16 - ENTRY_W)'(0), head};
        else                rd_word = {8'h00, head.data};
    end

endmodule

// File: rtl/rxf_status_fifo_chk.sv
module rxf_status_fifo_chk #(
    parameter int DEPTH = 1023,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             char_vld,
    input logic [7:0]       char_data,
    input logic             char_brk,
    input logic             char_frm,
    input logic             char_par,
    input logic             stat_mode,
    input logic [1:0]       trig_sel,
    input logic             cnt_clr,
    input logic             rd_en,
    input logic             stat_rd,
    input logic [15:0]      rd_word,
    input logic [CNT_W-1:0] rx_count,
    input logic             data_avail,
    input logic             trig,
    input logic [15:0]      stat_word
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        rx_count <= FULL_CNT); // R2

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_clr |=> ({1'b0, rx_count} == {1'b0, $past(rx_count)}
                   || {1'b0, rx_count} == {1'b0, $past(rx_count)} + 1'b1
                   || {1'b0, rx_count} + 1'b1 == {1'b0, $past(rx_count)})); // R2

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (char_vld && !rd_en && !cnt_clr && rx_count == FULL_CNT)
        |=> (stat_word[13] && rx_count == FULL_CNT)); // R3

    AST_EMPTY_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == '0) |-> (rd_word == 16'h0000)); // R4

    AST_MODE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_mode |-> (rd_word[15:8] == 8'h00)); // R4

    AST_STICKY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !char_vld) |=> (stat_word[13] == 1'b0 && stat_word[10:8] == 3'b000)); // R6

    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (rx_count == '0)); // R7

    AST_TRIG_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_sel == 2'd0) |-> !trig); // R8

    AST_TRIG_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_sel == 2'd1) |-> (trig == (rx_count != '0))); // R8

endmodule

bind rxf_status_fifo rxf_status_fifo_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_rxf_status_fifo.sv
module tb_rxf_status_fifo;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        char_vld = 1'b0;
    logic [7:0]  char_data = '0;
    logic        char_brk = 1'b0, char_frm = 1'b0, char_par = 1'b0;
    logic        stat_mode = 1'b0;
    logic [1:0]  trig_sel = 2'd0;
    logic        cnt_clr = 1'b0, rd_en = 1'b0, stat_rd = 1'b0;
    logic [15:0] rd_word, stat_word;
    logic [9:0]  rx_count;
    logic        data_avail, trig;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    rxf_status_fifo dut (
        .clk(clk), .rst_n(rst_n), .char_vld(char_vld), .char_data(char_data),
        .char_brk(char_brk), .char_frm(char_frm), .char_par(char_par),
        .stat_mode(stat_mode), .trig_sel(trig_sel), .cnt_clr(cnt_clr),
        .rd_en(rd_en), .stat_rd(stat_rd), .rd_word(rd_word), .rx_count(rx_count),
        .data_avail(data_avail), .trig(trig), .stat_word(stat_word)
    );

    // Row: vld, data, brk, frm, par, rd, mode | expected rd_word, expected count
    // (expectations are the values seen before the row's clock edge)
    localparam int NROW = 12;
    localparam logic [39:0] ROWS [NROW] = '{
        {1'b1, 8'h41, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 10'd0},
        {1'b1, 8'h5A, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0041, 10'd1},
        {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0041, 10'd2},
        {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0041, 10'd2},
        {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h015A, 10'd1},
        {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h005A, 10'd1},
        {1'b1, 8'h33, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 16'h015A, 10'd1},
        {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0C33, 10'd1},
        {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0C33, 10'd1},
        {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0000, 10'd0},
        {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0000, 10'd0},
        {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0000, 10'd0}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic push_n(input int n);
        for (int i = 0; i < n; i++) begin
            char_vld = 1'b1;
            char_data = 8'(i);
            cyc();
        end
        char_vld = 1'b0;
    endtask

    initial begin
        #(64'd200000 * 20);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1: reset state
        chk("R1", "count", 32'(rx_count), 0);
        chk("R1", "avail", 32'(data_avail), 0);
        chk("R1", "trig", 32'(trig), 0);
        chk("R1", "stat_word", 32'(stat_word), 0);
        chk("R1", "rd_word", 32'(rd_word), 0);
        rst_n = 1'b1;
        cyc();

        // R2 R4: order, count and read-word formatting
        for (int r = 0; r < NROW; r++) begin
            char_vld  = ROWS[r][39];
            char_data = ROWS[r][38:31];
            char_brk  = ROWS[r][30];
            char_frm  = ROWS[r][29];
            char_par  = ROWS[r][28];
            rd_en     = ROWS[r][27];
            stat_mode = ROWS[r][26];
            #1;
            chk("R4", $sformatf("row %0d rd_word", r), 32'(rd_word), 32'(ROWS[r][25:10]));
            chk("R2", $sformatf("row %0d count", r), 32'(rx_count), 32'(ROWS[r][9:0]));
            chk("R9", $sformatf("row %0d avail", r), 32'(data_avail), 32'(ROWS[r][9:0] != 0));
            cyc();
        end
        {char_vld, char_brk, char_frm, char_par, rd_en} = '0;

        // R5: sticky summary after the table
        chk("R5", "stat_word", 32'(stat_word), 32'h8700);
        stat_mode = 1'b0;
        #1;
        chk("R5", "mode bit low", 32'(stat_word), 32'h0700);
        stat_mode = 1'b1;

        // R6: read clears flags
        stat_rd = 1'b1;
        cyc();
        stat_rd = 1'b0;
        chk("R6", "after read", 32'(stat_word), 32'h8000);

        // R6: read and new parity event in the same cycle
        stat_rd = 1'b1;
        char_vld = 1'b1; char_data = 8'h11; char_par = 1'b1;
        cyc();
        {stat_rd, char_vld, char_par} = '0;
        chk("R6", "event beats read", 32'(stat_word), 32'h8101);

        // R7: clear together with a store
        cnt_clr = 1'b1; char_vld = 1'b1; char_data = 8'h22;
        cyc();
        cnt_clr = 1'b0; char_vld = 1'b0;
        chk("R7", "count after clear", 32'(rx_count), 0);
        chk("R7", "flags kept", 32'(stat_word), 32'h8100);

        // R8: trigger thresholds
        trig_sel = 2'd1;
        #1;
        chk("R8", "one, empty", 32'(trig), 0);
        push_n(1);
        chk("R8", "one, count 1", 32'(trig), 1);
        trig_sel = 2'd0;
        #1;
        chk("R8", "off", 32'(trig), 0);
        trig_sel = 2'd2;
        push_n(510);
        chk("R8", "half, 511", 32'(trig), 0);
        push_n(1);
        chk("R8", "half, 512", 32'(trig), 1);
        trig_sel = 2'd3;
        push_n(383);
        chk("R8", "7/8, 895", 32'(trig), 0);
        push_n(1);
        chk("R8", "7/8, 896", 32'(trig), 1);
        push_n(127);
        chk("R2", "full count", 32'(rx_count), 1023);

        // R2: store and pop together at full
        stat_rd = 1'b1;
        cyc();
        stat_rd = 1'b0;
        char_vld = 1'b1; rd_en = 1'b1; char_data = 8'hEE;
        cyc();
        char_vld = 1'b0; rd_en = 1'b0;
        chk("R2", "full push+pop count", 32'(rx_count), 1023);
        chk("R2", "full push+pop no overflow", 32'(stat_word[13]), 0);

        // R3: drop on full
        char_vld = 1'b1; char_data = 8'hDD;
        cyc();
        char_vld = 1'b0;
        chk("R3", "count stays full", 32'(rx_count), 1023);
        chk("R3", "overflow flag", 32'(stat_word[13]), 1);

        // R3: overrun marker on next stored character only
        cnt_clr = 1'b1;
        cyc();
        cnt_clr = 1'b0;
        char_vld = 1'b1; char_data = 8'h77;
        cyc();
        char_data = 8'h78;
        cyc();
        char_vld = 1'b0;
        chk("R3", "marked char", 32'(rd_word), 32'h0277);
        rd_en = 1'b1;
        cyc();
        rd_en = 1'b0;
        chk("R3", "following char", 32'(rd_word), 32'h0078);
        chk("R7", "flags survive clear", 32'(stat_word[13]), 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule